// File: doc/BRIEF.md
# Store-Gathering Write Queue with Ordering Barrier

This block sits between a load/store pipeline and an external bus and holds uncached and write-through stores until the bus takes them. Each entry holds one whole aligned block (32 bytes by default). A store that arrives while gathering is enabled can be folded into the youngest queued entry, so that several narrow writes leave as one wide, byte-masked bus write.

An ordering barrier can be pushed into the same queue. It travels as its own entry and leaves the queue as a separate broadcast transaction, without passing through any second-level cache path. The barrier blocks merging across it. It is not offered to the bus until every write issued before it has been acknowledged through a completion pulse. A zero-line request that carries the coherence attribute is always queued and broadcast. Cacheable stores and zero-line requests without the coherence attribute are accepted at the handshake and then discarded, because the local caches handle them.

Top module: `store_gather_queue`

## Requirements
- R1: After reset `inRdy` is 1 and `outValid` is 0.
- R2: Queued entries leave in the order they were created, each exactly once, and `outValid` is 0 whenever the queue is empty.
- R3: `inType` encodes 0 = cacheable, 1 = write-through, 2 = cache-inhibited. A cacheable store, or a zero-line request with `inCoherent` = 0, completes its handshake but creates no entry and produces no bus transaction.
- R4: A write leaves with `outType` = 0 and `outAddr` = the request address with its low 5 bits cleared. The 8 data bytes and 8 byte enables are placed at byte lane `inAddr[4:3]*8` of `outData`/`outBe`, and every other byte is zero.
- R5: With `gatherEn` = 1, a write merges into the youngest entry when that entry is a write in the same 32-byte block with the same `inType`. The byte enables are ORed, and the new bytes overwrite the old ones where they overlap.
- R6: A write never merges into a barrier entry or a zero-line entry, so stores on opposite sides of a barrier always stay separate. With `gatherEn` = 0, every kept write takes its own entry.
- R7: The entry at the head of the queue is never a merge target, so a store that arrives when exactly one entry is queued always takes a new entry.
- R8: A barrier leaves with `outType` = 1 and zero byte enables. It is offered only when no earlier write or zero-line transfer is still waiting for a `busDone` pulse.
- R9: A coherent zero-line request leaves with `outType` = 2, an aligned address, all 32 byte enables set and zero data.
- R10: Each write or zero-line transfer accepted by the bus raises the outstanding count by one, and each `busDone` pulse lowers it by one. A write or zero-line head is held back while the count equals `MAX_OUTST`.
- R11: `inRdy` is 0 exactly when `DEPTH` entries are occupied. A request offered then is not taken, even in a cycle in which the head leaves.
- R12: Once `outValid` is 1 with `outRdy` = 0, `outValid` and all transaction fields hold unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request valid |
| inRdy | output | 1 | Queue can take a request |
| inAddr | input | ADDR_W | Byte address of the request |
| inData | input | WORD_BYTES*8 | Store data |
| inBe | input | WORD_BYTES | Store byte enables |
| inType | input | 2 | Access type: 0 cacheable, 1 write-through, 2 cache-inhibited |
| inBarrier | input | 1 | Request is an ordering barrier |
| inZero | input | 1 | Request is a zero-line operation |
| inCoherent | input | 1 | Coherence attribute of a zero-line request |
| gatherEn | input | 1 | Gathering allowed for this request |
| outValid | output | 1 | Bus transaction offered |
| outRdy | input | 1 | Bus accepts the transaction |
| outType | output | 2 | 0 write, 1 barrier broadcast, 2 zero-line broadcast |
| outAddr | output | ADDR_W | Block-aligned address |
| outData | output | BLOCK_BYTES*8 | Block data |
| outBe | output | BLOCK_BYTES | Block byte enables |
| busDone | input | 1 | One pulse per completed write or zero-line transfer |

## Verification
The bench builds the queue with `DEPTH` = 4 and `MAX_OUTST` = 3, while the address and block widths keep their defaults. With these values a few requests fill the queue and expose the full-queue refusal. Three unacknowledged writes are enough to hit the outstanding limit, and a barrier can be kept waiting behind pending completions in a short run. Merge chains, overlap overwrites, type mismatches and barriers or zero-line entries sitting between mergeable stores all fit within four entries.

// File: rtl/sgq_pkg.sv
package sgq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'd0,
    OP_BARRIER = 2'd1,
    OP_ZERO    = 2'd2
  } busOp_e;

  localparam logic [1:0] ACC_CACHEABLE = 2'd0;

  typedef struct packed {
    logic push;
    logic merge;
    logic pop;
  } qStrobe_t;

endpackage

// File: rtl/sgq_data.sv
module sgq_data
  import sgq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 8,
  parameter int BLOCK_BYTES = 32,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int LANES  = BLOCK_BYTES / WORD_BYTES,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int BLK_W  = ADDR_W - OFF_W
) (
  input  logic                     clk,
  input  qStrobe_t                 strb,
  input  logic [IDX_W-1:0]         wrIdx,
  input  logic [IDX_W-1:0]         headIdx,
  input  logic [IDX_W-1:0]         youngIdx,
  input  busOp_e                   inOp,
  input  logic [1:0]               inType,
  input  logic [BLK_W-1:0]         inBlk,
  input  logic [LANE_W-1:0]        inLane,
  input  logic [WORD_BYTES*8-1:0]  inData,
  input  logic [WORD_BYTES-1:0]    inBe,
  output busOp_e                   headOp,
  output busOp_e                   youngOp,
  output logic [1:0]               youngType,
  output logic [BLK_W-1:0]         youngBlk,
  output logic [ADDR_W-1:0]        outAddr,
  output logic [BLOCK_BYTES*8-1:0] outData,
  output logic [BLOCK_BYTES-1:0]   outBe
);

  busOp_e                   opQ  [DEPTH];
  logic [1:0]               typQ [DEPTH];
  logic [BLK_W-1:0]         blkQ [DEPTH];
  logic [BLOCK_BYTES*8-1:0] datQ [DEPTH];
  logic [BLOCK_BYTES-1:0]   beQ  [DEPTH];

  logic [BLOCK_BYTES*8-1:0] placedData, mergedData;
  logic [BLOCK_BYTES-1:0]   placedBe;

  // Spread the narrow word onto its lane of the block.
  always_comb begin
    placedData = '0;
    placedBe   = '0;
    for (int l = 0; l < LANES; l++) begin
      if (inLane == LANE_W'(l)) begin
        placedData[l*WORD_BYTES*8 +: WORD_BYTES*8] = inData;
        placedBe[l*WORD_BYTES +: WORD_BYTES]       = inBe;
      end
    end
    if (inOp == OP_ZERO) begin
      placedData = '0;
      placedBe   = '1;
    end else if (inOp == OP_BARRIER) begin
      placedData = '0;
      placedBe   = '0;
    end
  end

  // Byte-wise overlay of the new store onto the youngest entry.
  generate
    for (genvar b = 0; b < BLOCK_BYTES; b++) begin : gMergeByte
      assign mergedData[b*8 +: 8] = placedBe[b] ? placedData[b*8 +: 8]
                                                : datQ[youngIdx][b*8 +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.push) begin
      opQ[wrIdx]  <= inOp;
      typQ[wrIdx] <= inType;
      blkQ[wrIdx] <= inBlk;
      datQ[wrIdx] <= placedData;
      beQ[wrIdx]  <= placedBe;
    end
    if (strb.merge) begin
      datQ[youngIdx] <= mergedData;
      beQ[youngIdx]  <= beQ[youngIdx] | placedBe;
    end
  end

  assign headOp    = opQ[headIdx];
  assign youngOp   = opQ[youngIdx];
  assign youngType = typQ[youngIdx];
  assign youngBlk  = blkQ[youngIdx];
  assign outAddr   = {blkQ[headIdx], {OFF_W{1'b0}}};
  assign outData   = datQ[headIdx];
  assign outBe     = beQ[headIdx];

endmodule

// File: rtl/sgq_ctrl.sv
module sgq_ctrl
  import sgq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int MAX_OUTST   = 15,
  parameter int BLK_W       = 27,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int OST_W = $clog2(MAX_OUTST + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inBarrier,
  input  logic             inZero,
  input  logic             inCoherent,
  input  logic [1:0]       inType,
  input  logic [BLK_W-1:0] inBlk,
  input  logic             gatherEn,
  input  logic             outRdy,
  input  logic             busDone,
  input  busOp_e           headOp,
  input  busOp_e           youngOp,
  input  logic [1:0]       youngType,
  input  logic [BLK_W-1:0] youngBlk,
  output logic             inRdy,
  output logic             outValid,
  output qStrobe_t         strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] youngIdx,
  output logic [CNT_W-1:0] qCount
);

  logic [IDX_W-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0] count;
  logic [OST_W-1:0] outst;
  logic             accept, keep, isWrite, canMerge, issueCounted, retire;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign inRdy    = (count != CNT_W'(DEPTH));
  assign accept   = inValid && inRdy;
  assign isWrite  = !inBarrier && !inZero;
  assign keep     = inBarrier || (inZero ? inCoherent : (inType != ACC_CACHEABLE));
  assign youngIdx = (tailPtr == '0) ? IDX_W'(DEPTH - 1) : tailPtr - 1'b1;

  // Merge target must be a write beyond the head, same block and type.
  assign canMerge = gatherEn && isWrite && (count > CNT_W'(1)) &&
                    (youngOp == OP_WRITE) && (youngType == inType) &&
                    (youngBlk == inBlk);

  assign outValid = (count != '0) &&
                    ((headOp == OP_BARRIER) ? (outst == '0)
                                            : (outst != OST_W'(MAX_OUTST)));

  always_comb begin
    strb.push  = accept && keep && !canMerge;
    strb.merge = accept && keep && canMerge;
    strb.pop   = outValid && outRdy;
  end

  assign issueCounted = strb.pop && (headOp != OP_BARRIER);
  assign retire       = busDone && (outst != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
      outst   <= '0;
    end else begin
      if (strb.push) tailPtr <= nextIdx(tailPtr);
      if (strb.pop)  headPtr <= nextIdx(headPtr);
      count <= count + CNT_W'(strb.push) - CNT_W'(strb.pop);
      outst <= outst + OST_W'(issueCounted) - OST_W'(retire);
    end
  end

  assign wrIdx   = tailPtr;
  assign headIdx = headPtr;
  assign qCount  = count;

endmodule

// File: rtl/store_gather_queue.sv
module store_gather_queue
  import sgq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int MAX_OUTST   = 15,
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 8,
  parameter int BLOCK_BYTES = 32,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int WOFF_W = $clog2(WORD_BYTES),
  localparam int LANES  = BLOCK_BYTES / WORD_BYTES,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int BLK_W  = ADDR_W - OFF_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inRdy,
  input  logic [ADDR_W-1:0]        inAddr,
  input  logic [WORD_BYTES*8-1:0]  inData,
  input  logic [WORD_BYTES-1:0]    inBe,
  input  logic [1:0]               inType,
  input  logic                     inBarrier,
  input  logic                     inZero,
  input  logic                     inCoherent,
  input  logic                     gatherEn,
  output logic                     outValid,
  input  logic                     outRdy,
  output logic [1:0]               outType,
  output logic [ADDR_W-1:0]        outAddr,
  output logic [BLOCK_BYTES*8-1:0] outData,
  output logic [BLOCK_BYTES-1:0]   outBe,
  input  logic                     busDone
);

  qStrobe_t         strb;
  busOp_e           inOp, headOp, youngOp;
  logic [1:0]       youngType;
  logic [BLK_W-1:0] youngBlk, inBlk;
  logic [LANE_W-1:0] inLane;
  logic [IDX_W-1:0] wrIdx, headIdx, youngIdx;
  logic [CNT_W-1:0] qCount;
  logic             unusedLowAddr;

  assign inBlk         = inAddr[ADDR_W-1:OFF_W];
  assign inLane        = inAddr[OFF_W-1:WOFF_W];
  assign unusedLowAddr = ^inAddr[WOFF_W-1:0];
  assign inOp          = inBarrier ? OP_BARRIER : (inZero ? OP_ZERO : OP_WRITE);
  assign outType       = headOp;

  sgq_ctrl #(
    .DEPTH(DEPTH), .MAX_OUTST(MAX_OUTST), .BLK_W(BLK_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBarrier(inBarrier),
    .inZero(inZero), .inCoherent(inCoherent), .inType(inType), .inBlk(inBlk),
    .gatherEn(gatherEn), .outRdy(outRdy), .busDone(busDone),
    .headOp(headOp), .youngOp(youngOp), .youngType(youngType),
    .youngBlk(youngBlk), .inRdy(inRdy), .outValid(outValid), .strb(strb),
    .wrIdx(wrIdx), .headIdx(headIdx), .youngIdx(youngIdx), .qCount(qCount)
  );

  sgq_data #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_data (
    .clk(clk), .strb(strb), .wrIdx(wrIdx), .headIdx(headIdx),
    .youngIdx(youngIdx), .inOp(inOp), .inType(inType), .inBlk(inBlk),
    .inLane(inLane), .inData(inData), .inBe(inBe), .headOp(headOp),
    .youngOp(youngOp), .youngType(youngType), .youngBlk(youngBlk),
    .outAddr(outAddr), .outData(outData), .outBe(outBe)
  );

endmodule

// File: rtl/sgq_checker.sv
module sgq_checker #(
  parameter int DEPTH       = 8,
  parameter int MAX_OUTST   = 15,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int OFF_W = $clog2(BLOCK_BYTES)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inRdy,
  input logic                     outValid,
  input logic                     outRdy,
  input logic [1:0]               outType,
  input logic [ADDR_W-1:0]        outAddr,
  input logic [BLOCK_BYTES*8-1:0] outData,
  input logic [BLOCK_BYTES-1:0]   outBe,
  input logic                     busDone,
  input logic [CNT_W-1:0]         qCount
);

  // Independent tally of bus transfers still awaiting completion.
  logic [31:0] chkOut;
  always_ff @(posedge clk) begin
    if (!rstN) chkOut <= '0;
    else chkOut <= chkOut + 32'(outValid && outRdy && outType != 2'd1)
                          - 32'(busDone && chkOut != '0);
  end

  AST_BARRIER_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outType == 2'd1 |-> chkOut == '0); // R8
  AST_OUTST_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    chkOut <= 32'(MAX_OUTST)); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outRdy |=> outValid && $stable(outType) && $stable(outAddr)
                            && $stable(outData) && $stable(outBe)); // R12
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(DEPTH)); // R11
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    inRdy |-> qCount != CNT_W'(DEPTH)); // R11
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    qCount == '0 |-> !outValid); // R2
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outAddr[OFF_W-1:0] == '0 && outType != 2'd3); // R4

endmodule

bind store_gather_queue sgq_checker #(
  .DEPTH(DEPTH), .MAX_OUTST(MAX_OUTST), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .inRdy(inRdy), .outValid(outValid), .outRdy(outRdy),
  .outType(outType), .outAddr(outAddr), .outData(outData), .outBe(outBe),
  .busDone(busDone), .qCount(qCount)
);

// File: tb/store_gather_queue_tb.sv
module store_gather_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int MAX_OUTST = 3;
  localparam int ADDR_W = 32;
  localparam int WB = 8;
  localparam int BB = 32;
  localparam int BLK_W = ADDR_W - 5;

  logic clk = 0, rstN = 0;
  logic inValid = 0, inBarrier = 0, inZero = 0, inCoherent = 0, gatherEn = 0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic [WB*8-1:0] inData = '0;
  logic [WB-1:0] inBe = '0;
  logic [1:0] inType = '0;
  logic outRdy = 0, busDone = 0;
  logic inRdy, outValid;
  logic [1:0] outType;
  logic [ADDR_W-1:0] outAddr;
  logic [BB*8-1:0] outData;
  logic [BB-1:0] outBe;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_gather_queue #(.DEPTH(DEPTH), .MAX_OUTST(MAX_OUTST)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRdy(inRdy), .inAddr(inAddr),
    .inData(inData), .inBe(inBe), .inType(inType), .inBarrier(inBarrier),
    .inZero(inZero), .inCoherent(inCoherent), .gatherEn(gatherEn),
    .outValid(outValid), .outRdy(outRdy), .outType(outType), .outAddr(outAddr),
    .outData(outData), .outBe(outBe), .busDone(busDone)
  );

  typedef struct {
    int op;
    int typ;
    logic [BLK_W-1:0] blk;
    logic [BB*8-1:0] data;
    logic [BB-1:0] be;
  } ment_t;

  ment_t mq[$];
  int mOutst = 0;
  int nRun = 0, nFail = 0, cyc = 0;
  string curReq = "R1";
  bit autoDone = 1, finished = 0;

  function automatic bit mValid();
    if (mq.size() == 0) return 0;
    if (mq[0].op == 1) return mOutst == 0;
    return mOutst < MAX_OUTST;
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [BB*8-1:0] act, input logic [BB*8-1:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  // Reference model, advanced on each rising edge.
  always @(posedge clk) begin
    ment_t t;
    logic [BB*8-1:0] pData;
    logic [BB-1:0] pBe;
    int lane;
    bit keep, isW, acc, canM, pop, inc, dec;
    cyc++;
    if (!rstN) begin
      mq.delete();
      mOutst = 0;
    end else begin
      lane = int'(inAddr[4:3]);
      pData = '0; pBe = '0;
      pData[lane*64 +: 64] = inData;
      pBe[lane*8 +: 8] = inBe;
      isW = !inBarrier && !inZero;
      keep = inBarrier || (inZero ? inCoherent : inType != 2'd0);
      acc = inValid && (mq.size() < DEPTH);
      canM = gatherEn && isW && mq.size() >= 2 && mq[$].op == 0 &&
             mq[$].typ == int'(inType) && mq[$].blk == inAddr[31:5];
      pop = mValid() && outRdy;
      inc = pop && mq[0].op != 1;
      dec = busDone && mOutst > 0;
      if (pop) void'(mq.pop_front());
      mOutst = mOutst + int'(inc) - int'(dec);
      if (acc && keep) begin
        if (canM) begin
          t = mq[$];
          for (int b = 0; b < BB; b++)
            if (pBe[b]) t.data[b*8 +: 8] = pData[b*8 +: 8];
          t.be = t.be | pBe;
          mq[$] = t;
        end else begin
          t.op = inBarrier ? 1 : (inZero ? 2 : 0);
          t.typ = int'(inType);
          t.blk = inAddr[31:5];
          t.data = (t.op == 0) ? pData : '0;
          t.be = (t.op == 0) ? pBe : ((t.op == 2) ? '1 : '0);
          mq.push_back(t);
        end
      end
    end
  end

  // Compare with the model away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(inRdy === (mq.size() < DEPTH), "inRdy", BB*8'(inRdy), BB*8'(mq.size() < DEPTH));
      chk(outValid === mValid(), "outValid", BB*8'(outValid), BB*8'(mValid()));
      if (mValid() && outValid) begin
        chk(outType === 2'(mq[0].op), "outType", BB*8'(outType), BB*8'(mq[0].op));
        chk(outAddr === {mq[0].blk, 5'b0}, "outAddr", BB*8'(outAddr), BB*8'({mq[0].blk, 5'b0}));
        chk(outData === mq[0].data, "outData", outData, mq[0].data);
        chk(outBe === mq[0].be, "outBe", BB*8'(outBe), BB*8'(mq[0].be));
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
    inValid = 0; inBarrier = 0; inZero = 0; inCoherent = 0;
    busDone = autoDone && (mOutst > 0) && (cyc % 2 == 0);
  endtask

  task automatic put(input logic [31:0] a, input logic [63:0] d,
                     input logic [7:0] be, input logic [1:0] ty, input bit g);
    step();
    inValid = 1; inAddr = a; inData = d; inBe = be; inType = ty; gatherEn = g;
  endtask

  task automatic barrierReq();
    step();
    inValid = 1; inBarrier = 1; inType = 2'd2;
  endtask

  task automatic zeroReq(input logic [31:0] a, input bit coh);
    step();
    inValid = 1; inZero = 1; inCoherent = coh; inAddr = a; inType = 2'd1;
  endtask

  task automatic drain();
    outRdy = 1; autoDone = 1;
    for (int i = 0; i < 200 && (mq.size() != 0 || mOutst != 0); i++) step();
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    curReq = "R1";
    chk(inRdy === 1'b1, "R1 reset inRdy", BB*8'(inRdy), 1);
    chk(outValid === 1'b0, "R1 reset outValid", BB*8'(outValid), 0);

    curReq = "R4";  // also R2: order of mixed writes
    outRdy = 1;
    put(32'h0000_1000, 64'h1111_2222_3333_4444, 8'hFF, 2'd1, 0);
    put(32'h0000_1018, 64'hAAAA_BBBB_CCCC_DDDD, 8'h3C, 2'd2, 0);
    put(32'h0000_1408, 64'h0102_0304_0506_0708, 8'h81, 2'd1, 0);
    curReq = "R2";
    put(32'h0000_2010, 64'h5555_6666_7777_8888, 8'h0F, 2'd2, 0);
    drain();

    curReq = "R3";
    outRdy = 0;
    put(32'h0000_3000, 64'hDEAD_BEEF_0000_0001, 8'hFF, 2'd0, 1);
    zeroReq(32'h0000_3040, 0);
    step(); step(); step();
    chk(outValid === 1'b0, "R3 discarded request", BB*8'(outValid), 0);

    curReq = "R5";
    put(32'h0000_4000, 64'h0A0A_0A0A_0A0A_0A0A, 8'hFF, 2'd1, 1);
    put(32'h0000_5008, 64'h1234_5678_9ABC_DEF0, 8'h0F, 2'd1, 1);
    put(32'h0000_5010, 64'hFEDC_BA98_7654_3210, 8'hFF, 2'd1, 1);
    put(32'h0000_5008, 64'hCAFE_F00D_BEEF_1234, 8'hF8, 2'd1, 1);
    put(32'h0000_5000, 64'h7777_7777_7777_7777, 8'hFF, 2'd2, 1);
    put(32'h0000_5018, 64'h9999_9999_9999_9999, 8'hFF, 2'd1, 0);
    step();
    chk(inRdy === 1'b0, "R5 four entries after two merges", BB*8'(inRdy), 0);
    drain();

    curReq = "R7";
    outRdy = 0;
    put(32'h0000_6000, 64'h1, 8'h01, 2'd1, 1);
    put(32'h0000_6008, 64'h2, 8'h01, 2'd1, 1);
    drain();

    curReq = "R6";
    outRdy = 0;
    put(32'h0000_7000, 64'h11, 8'hFF, 2'd1, 1);
    barrierReq();
    put(32'h0000_7008, 64'h22, 8'hFF, 2'd1, 1);
    put(32'h0000_7010, 64'h33, 8'hFF, 2'd1, 1);
    zeroReq(32'h0000_7000, 1);
    drain();
    outRdy = 0;
    put(32'h0000_8000, 64'h44, 8'hFF, 2'd2, 1);
    zeroReq(32'h0000_8000, 1);
    put(32'h0000_8008, 64'h55, 8'hFF, 2'd2, 1);
    put(32'h0000_8010, 64'h66, 8'hFF, 2'd2, 0);
    drain();

    curReq = "R8";
    autoDone = 0;
    outRdy = 1;
    put(32'h0000_9000, 64'h1, 8'hFF, 2'd2, 0);
    put(32'h0000_9400, 64'h2, 8'hFF, 2'd2, 0);
    barrierReq();
    put(32'h0000_9000, 64'h3, 8'hFF, 2'd2, 0);
    step(); step(); step();
    chk(outValid === 1'b0, "R8 barrier held behind pending writes", BB*8'(outValid), 0);
    drain();

    curReq = "R10";
    autoDone = 0;
    outRdy = 1;
    for (int i = 0; i < 4; i++) put(32'h0000_A000 + 32'(i*64), 64'(i), 8'hFF, 2'd1, 0);
    step(); step(); step();
    chk(outValid === 1'b0, "R10 limit reached", BB*8'(outValid), 0);
    drain();

    curReq = "R9";
    zeroReq(32'h0000_B05C, 1);
    drain();

    curReq = "R11";
    outRdy = 0;
    for (int i = 0; i < 5; i++) put(32'h0000_C000 + 32'(i*64), 64'(i+7), 8'hFF, 2'd2, 0);
    step();
    chk(inRdy === 1'b0, "R11 full refuses", BB*8'(inRdy), 0);
    step(); outRdy = 1;
    inValid = 1; inAddr = 32'h0000_CF00; inData = 64'hBAD; inBe = 8'hFF; inType = 2'd1;
    drain();

    curReq = "R12";
    for (int i = 0; i < 12; i++) begin
      put(32'h0000_D000 + 32'(i*8), 64'(i*3+1), 8'hFF, 2'(1 + (i % 2)), 1);
      outRdy = (i % 3 == 0);
    end
    drain();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog expired actual=hang expected=completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule